// File: doc/BRIEF.md
# Glitch-Free Clock Mode Controller

This block derives a set of processor clocks, one early processor clock and a set of bus clocks from a fast reference clock, which stands in for the output of an on-chip PLL. A two-bit frequency code picks one of four base rates. A doze input halves all divided rates. A bus-ratio input runs the bus clocks at the processor rate or at half of it. A stop input parks the processor clocks low without cutting any pulse short.

A three-bit mode request adds a park state (every divided clock low), a power-down state (the divider held idle) and a high-impedance state (modelled as an output enable driven low). Power-down is entered only from park, and only once every divided output has settled low. It is always left back into park. The fixed-rate peripheral clocks are represented by a single enable. All control inputs pass through a two-flop synchronizer into the reference domain.

Rate changes take effect only at a frame boundary, where every divided output is low. As a result, no output pulse is ever cut short or stretched to an odd width.

Top module: `clk_mode_ctrl`

## Requirements
- R1: The processor clock period is 2*H reference cycles, with a 50% duty cycle. H is 9, 10, 12 or 18 for fsel 00, 01, 10 or 11 (about 66.6, 60, 50 and 33.3 MHz relative to each other).
- R2: With bus_full=1 the bus clock period equals the processor clock period. With bus_full=0 it is twice the processor clock period.
- R3: With doze_n=0 the processor, early and bus clock periods are all doubled, so the bus runs at F/4 when bus_full=0.
- R4: In a run mode with stop_n=0, the processor and early clocks stay low, and each high pulse in progress completes at full width. The bus clocks keep running. After stop_n returns to 1, the clocks resume with full-width pulses.
- R5: Mode request 000 (power-down) holds every processor, early and bus clock low, drives pll_active=0 and drives fixed_en=0.
- R6: Power-down is reached only through park: at least one cycle with pll_active=1 and fixed_en=0 comes before pll_active falls. Leaving power-down passes through park: pll_active rises at least one cycle before fixed_en rises.
- R7: Mode request 001 (park) holds every processor, early and bus clock low, drives fixed_en=0 and keeps pll_active=1.
- R8: Mode request 010 drives out_en=0 while the clocks keep toggling internally. Every other mode drives out_en=1. The run codes are 011 to 111, and they drive fixed_en=1.
- R9: The early clock has the same frequency as the processor clock, and each of its rising edges comes exactly one reference cycle before the processor clock's rising edge.
- R10: Every high pulse on the processor, early and bus clocks lasts H*m reference cycles for a legal H and m in {1,2,4}. No low phase is shorter than 9 cycles, including across rate changes and stop or mode transitions.
- R11: After reset the block is in park: all divided clocks are low, fixed_en=0, pll_active=1 and out_en=1.
- R12: All NUM_CPU processor clock outputs are identical at every cycle, and all NUM_BUS bus clock outputs are identical at every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_req | input | 3 | Mode request: 000 power-down, 001 park, 010 high-impedance, others run |
| fsel | input | 2 | Base frequency select |
| doze_n | input | 1 | Active-low doze, halves all divided rates |
| bus_full | input | 1 | 1: bus at processor rate, 0: bus at half rate |
| stop_n | input | 1 | Active-low stop for the processor and early clocks |
| ecpu_clk | output | 1 | Early processor clock |
| cpu_clk | output | NUM_CPU | Processor clock copies |
| bus_clk | output | NUM_BUS | Bus clock copies |
| fixed_en | output | 1 | Enable for the fixed-rate peripheral clocks |
| pll_active | output | 1 | Low while the clock generation is powered down |
| out_en | output | 1 | Clock output drive enable (low means high impedance) |

## Verification
A divider or settings register in the wrong state shows up within one frame, at most 144 reference cycles, as a wrong period or as a high pulse whose width is not a legal multiple. The pulse-width monitor catches this on the next falling edge. A stuck output gate shows up as a processor clock that keeps running through a stop, or that never returns after release, within a few hundred cycles. A mode state machine that skips park shows up as pll_active and fixed_en changing in the same cycle.

// File: rtl/ckm_pkg.sv
// Shared types and mode encodings for the clock mode controller.
// Assumes a three-bit mode request; codes not listed here select run.
package ckm_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_PARK = 2'd1,
        ST_DOWN = 2'd2,
        ST_HIZ  = 2'd3
    } ckm_state_e;

    localparam logic [2:0] MODE_DOWN = 3'b000;
    localparam logic [2:0] MODE_PARK = 3'b001;
    localparam logic [2:0] MODE_HIZ  = 3'b010;
endpackage

// File: rtl/ckm_sync.sv
// Two-flop synchronizer for a control vector that enters the reference domain.
// Assumes each bit is quasi-static, so a per-bit settle is acceptable.
module ckm_sync #(
    parameter int           W    = 1,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Shift the inputs through two flops; reset loads the safe value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= INIT;
            q      <= INIT;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/ckm_mode_fsm.sv
// Mode state machine: maps the synchronized request onto run, park,
// power-down and high-impedance states. Power-down is entered only from
// park once every output reports parked, and it is left only back into park.
module ckm_mode_fsm
    import ckm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] req,
    input  logic       parked,
    output ckm_state_e state_q
);
    ckm_state_e state_d;

    // Translate a request code into the state it asks for.
    function automatic ckm_state_e decode(input logic [2:0] code);
        case (code)
            MODE_DOWN: return ST_DOWN;
            MODE_PARK: return ST_PARK;
            MODE_HIZ:  return ST_HIZ;
            default:   return ST_RUN;
        endcase
    endfunction

    // Choose the next state while honouring the power-down detour rule.
    always_comb begin
        case (state_q)
            ST_DOWN: state_d = (req == MODE_DOWN) ? ST_DOWN : ST_PARK;
            ST_PARK: state_d = (decode(req) == ST_DOWN && !parked) ? ST_PARK : decode(req);
            default: state_d = (req == MODE_DOWN) ? ST_PARK : decode(req);
        endcase
    end

    // Hold the state; reset lands in park.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_PARK;
        else        state_q <= state_d;
    end

    // R6: power-down is never reached except from park
    a_r6_pd_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_DOWN && state_q != ST_PARK) |=> (state_q != ST_DOWN));
    // R6: power-down only ever exits to park
    a_r6_pd_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DOWN) |=> (state_q == ST_DOWN || state_q == ST_PARK));
    // R6: park does not hand over to power-down before outputs settle
    a_r6_pd_parked: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PARK && !parked) |=> (state_q != ST_DOWN));
endmodule

// File: rtl/ckm_divider.sv
// Reference divider. A half-period counter drives a three-bit toggle
// counter whose bits give the x1, x1/2 and x1/4 phases. The frequency select,
// doze and bus ratio are latched only when the toggle counter wraps, where
// every derived phase is low. Held idle while run is low.
module ckm_divider #(
    parameter int HALF_F0 = 9,
    parameter int HALF_F1 = 10,
    parameter int HALF_F2 = 12,
    parameter int HALF_F3 = 18
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] fsel,
    input  logic       doze_n,
    input  logic       bus_full,
    output logic       nat_cpu,
    output logic       nat_bus
);
    localparam int HMAX01 = (HALF_F0 > HALF_F1) ? HALF_F0 : HALF_F1;
    localparam int HMAX23 = (HALF_F2 > HALF_F3) ? HALF_F2 : HALF_F3;
    localparam int HMAX   = (HMAX01 > HMAX23) ? HMAX01 : HMAX23;
    localparam int CW     = (HMAX > 2) ? $clog2(HMAX) : 1;

    logic [CW-1:0] hcnt;
    logic [CW-1:0] lim;
    logic [2:0]    phase;
    logic          cur_doze;
    logic          cur_busfull;

    // Terminal count of the half-period counter for a select code.
    function automatic logic [CW-1:0] lim_of(input logic [1:0] s);
        case (s)
            2'd0:    return CW'(HALF_F0 - 1);
            2'd1:    return CW'(HALF_F1 - 1);
            2'd2:    return CW'(HALF_F2 - 1);
            default: return CW'(HALF_F3 - 1);
        endcase
    endfunction

    // Count half periods, advance the phase and latch settings at the frame wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            hcnt        <= '0;
            phase       <= '0;
            lim         <= lim_of(fsel);
            cur_doze    <= !doze_n;
            cur_busfull <= bus_full;
        end else if (hcnt == lim) begin
            hcnt  <= '0;
            phase <= phase + 3'd1;
            if (phase == 3'd7) begin
                lim         <= lim_of(fsel);
                cur_doze    <= !doze_n;
                cur_busfull <= bus_full;
            end
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end

    // Pick the phase bits that form the ungated processor and bus clocks.
    always_comb begin
        nat_cpu = cur_doze ? phase[1] : phase[0];
        if (cur_busfull) nat_bus = nat_cpu;
        else             nat_bus = cur_doze ? phase[2] : phase[1];
    end
endmodule

// File: rtl/clk_mode_ctrl.sv
// Top of the clock mode controller. Synchronizes the controls, runs the
// mode state machine and the divider, and gates each clock with an enable
// that may change only while that clock's source is low. The early clock is
// the first gated register. The processor and bus clocks sit one reference
// cycle later, so the early edge leads by exactly one cycle.
// Assumes every half period is at least two reference cycles.
module clk_mode_ctrl
    import ckm_pkg::*;
#(
    parameter int HALF_F0 = 9,
    parameter int HALF_F1 = 10,
    parameter int HALF_F2 = 12,
    parameter int HALF_F3 = 18,
    parameter int NUM_CPU = 3,
    parameter int NUM_BUS = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         mode_req,
    input  logic [1:0]         fsel,
    input  logic               doze_n,
    input  logic               bus_full,
    input  logic               stop_n,
    output logic               ecpu_clk,
    output logic [NUM_CPU-1:0] cpu_clk,
    output logic [NUM_BUS-1:0] bus_clk,
    output logic               fixed_en,
    output logic               pll_active,
    output logic               out_en
);
    localparam int          SW       = 8;
    localparam logic [SW-1:0] SYNC_INIT = {MODE_PARK, 2'b00, 1'b1, 1'b0, 1'b0};

    logic [SW-1:0] ctl_s;
    logic [2:0]    mode_s;
    logic [1:0]    fsel_s;
    logic          doze_s, busf_s, stop_s;
    ckm_state_e    state;
    logic          nat_cpu, nat_bus;
    logic          gate_e, gate_b;
    logic          ecpu_q, cpu_q, bus_pre, bus_q;
    logic          clocks_on, want_e, parked;

    ckm_sync #(.W(SW), .INIT(SYNC_INIT)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({mode_req, fsel, doze_n, bus_full, stop_n}),
        .q(ctl_s)
    );
    assign {mode_s, fsel_s, doze_s, busf_s, stop_s} = ctl_s;

    ckm_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req(mode_s), .parked(parked), .state_q(state)
    );

    ckm_divider #(
        .HALF_F0(HALF_F0), .HALF_F1(HALF_F1), .HALF_F2(HALF_F2), .HALF_F3(HALF_F3)
    ) u_div (
        .clk(clk), .rst_n(rst_n), .run(state != ST_DOWN),
        .fsel(fsel_s), .doze_n(doze_s), .bus_full(busf_s),
        .nat_cpu(nat_cpu), .nat_bus(nat_bus)
    );

    // Decide which clock groups the current state lets run.
    always_comb begin
        clocks_on = (state == ST_RUN) || (state == ST_HIZ);
        want_e    = clocks_on && stop_s;
        parked    = !(gate_e || gate_b || ecpu_q || cpu_q || bus_pre || bus_q);
    end

    // Gate and retime the clocks; enables move only while their source is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_e  <= 1'b0;
            gate_b  <= 1'b0;
            ecpu_q  <= 1'b0;
            cpu_q   <= 1'b0;
            bus_pre <= 1'b0;
            bus_q   <= 1'b0;
        end else begin
            if (!nat_cpu) gate_e <= want_e;
            ecpu_q  <= nat_cpu & gate_e;
            cpu_q   <= ecpu_q;
            bus_pre <= nat_bus;
            if (!bus_pre) gate_b <= clocks_on;
            bus_q   <= bus_pre & gate_b;
        end
    end

    assign ecpu_clk   = ecpu_q;
    assign fixed_en   = clocks_on;
    assign pll_active = (state != ST_DOWN);
    assign out_en     = (state != ST_HIZ);

    for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
        assign cpu_clk[i] = cpu_q;
    end
    for (genvar j = 0; j < NUM_BUS; j++) begin : g_bus
        assign bus_clk[j] = bus_q;
    end

    // R5: every divided clock is low throughout power-down
    a_r5_down_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DOWN) |-> !(ecpu_q || cpu_q || bus_q));
    // R10: a processor clock high phase never lasts a single cycle
    a_r10_no_sliver: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_q) |=> cpu_q);
    // R9: each early rising edge is followed one cycle later by the processor edge
    a_r9_lead: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ecpu_q) |=> $rose(cpu_q));
endmodule

// File: tb/test_clk_mode_ctrl.sv
module test_clk_mode_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam int NCPU = 3;
    localparam int NBUS = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [2:0]      mode_req = 3'b001;
    logic [1:0]      fsel = 2'b00;
    logic            doze_n = 1'b1;
    logic            bus_full = 1'b0;
    logic            stop_n = 1'b1;
    logic            ecpu_clk;
    logic [NCPU-1:0] cpu_clk;
    logic [NBUS-1:0] bus_clk;
    logic            fixed_en, pll_active, out_en;

    int n_cmp = 0;
    int n_bad = 0;
    int runt_cnt = 0;
    bit mon_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clk_mode_ctrl i_clk_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .fsel(fsel),
        .doze_n(doze_n), .bus_full(bus_full), .stop_n(stop_n),
        .ecpu_clk(ecpu_clk), .cpu_clk(cpu_clk), .bus_clk(bus_clk),
        .fixed_en(fixed_en), .pll_active(pll_active), .out_en(out_en)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int half_of(input logic [1:0] s);
        case (s)
            2'd0: return 9;
            2'd1: return 10;
            2'd2: return 12;
            default: return 18;
        endcase
    endfunction

    function automatic int exp_cpu_per(input logic [1:0] s, input logic dz_n);
        return 2 * half_of(s) * (dz_n ? 1 : 2);
    endfunction

    function automatic int exp_bus_per(input logic [1:0] s, input logic dz_n, input logic bf);
        return exp_cpu_per(s, dz_n) * (bf ? 1 : 2);
    endfunction

    function automatic bit legal_high(input int w);
        for (int s = 0; s < 4; s++)
            for (int m = 1; m <= 4; m = m * 2)
                if (w == half_of(2'(s)) * m) return 1'b1;
        return 1'b0;
    endfunction

    // Pulse-width monitor on early, processor and bus clocks (R10)
    logic [2:0] mon_prev;
    int         mon_w [3];
    bit         mon_seen [3];
    always @(negedge clk) begin
        logic [2:0] cur;
        cur = {bus_clk[0], cpu_clk[0], ecpu_clk};
        for (int i = 0; i < 3; i++) begin
            if (!mon_on) begin
                mon_seen[i] = 1'b0;
                mon_w[i] = 1;
            end else if (cur[i] == mon_prev[i]) begin
                mon_w[i]++;
            end else begin
                if (mon_seen[i]) begin
                    if (mon_prev[i] && !legal_high(mon_w[i])) begin
                        runt_cnt++;
                        $display("runt high pulse on output %0d width=%0d at %0t", i, mon_w[i], $time);
                    end
                    if (!mon_prev[i] && mon_w[i] < 9) begin
                        runt_cnt++;
                        $display("short low phase on output %0d width=%0d at %0t", i, mon_w[i], $time);
                    end
                end
                mon_seen[i] = 1'b1;
                mon_w[i] = 1;
            end
        end
        mon_prev = cur;
    end

    // Measure processor period, high width, early lead and copy equality
    task automatic meas_cpu(output int per, output int hi, output bit lead_ok, output bit copies_ok);
        copies_ok = 1'b1;
        @(negedge clk);
        while (ecpu_clk) @(negedge clk);
        while (!ecpu_clk) @(negedge clk);
        lead_ok = (cpu_clk[0] == 1'b0);
        @(negedge clk);
        lead_ok = lead_ok && (cpu_clk[0] == 1'b1);
        hi = 0;
        do begin
            hi++;
            if (cpu_clk != {NCPU{1'b0}} && cpu_clk != {NCPU{1'b1}}) copies_ok = 1'b0;
            @(negedge clk);
        end while (cpu_clk[0]);
        per = hi;
        while (!cpu_clk[0]) begin
            per++;
            if (cpu_clk != {NCPU{1'b0}}) copies_ok = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic meas_bus(output int per, output bit copies_ok);
        copies_ok = 1'b1;
        @(negedge clk);
        while (bus_clk[0]) @(negedge clk);
        while (!bus_clk[0]) @(negedge clk);
        per = 0;
        do begin
            per++;
            if (bus_clk != {NBUS{1'b1}}) copies_ok = 1'b0;
            @(negedge clk);
        end while (bus_clk[0]);
        while (!bus_clk[0]) begin
            per++;
            if (bus_clk != {NBUS{1'b0}}) copies_ok = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Check that all divided clocks stay low for a window
    task automatic check_quiet(input int n, input string req);
        int highs = 0;
        repeat (n) begin
            @(negedge clk);
            if (ecpu_clk || cpu_clk != '0 || bus_clk != '0) highs++;
        end
        chk(highs == 0, req, highs, 0);
    endtask

    // Enter power-down and verify the park detour (R6)
    task automatic enter_down(input string tag);
        int gap = 0;
        mode_req = 3'b000;
        @(negedge clk);
        while (pll_active) begin
            if (!fixed_en) gap++;
            @(negedge clk);
        end
        chk(gap >= 1, {"R6 entry via park ", tag}, gap, 1);
    endtask

    initial begin
        int per, hi, bper, bcnt, ehigh;
        bit lead_ok, cp_ok, bcp_ok;
        void'($urandom(32'd20240611));
        idle(5);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state is park
        chk(ecpu_clk == 0 && cpu_clk == '0 && bus_clk == '0, "R11 clocks low", int'(cpu_clk), 0);
        chk(fixed_en == 0, "R11 fixed_en", fixed_en, 0);
        chk(pll_active == 1 && out_en == 1, "R11 pll_active/out_en", {pll_active, out_en}, 3);
        mon_on = 1'b1;

        // Random run configurations (R1 R2 R3 R8 R9 R12)
        for (int it = 0; it < 12; it++) begin
            fsel     = 2'($urandom % 4);
            doze_n   = 1'($urandom % 2);
            bus_full = 1'($urandom % 2);
            mode_req = 3'(3 + $urandom % 5);
            stop_n   = 1'b1;
            idle(400);
            meas_cpu(per, hi, lead_ok, cp_ok);
            chk(per == exp_cpu_per(fsel, doze_n), "R1/R3 cpu period", per, exp_cpu_per(fsel, doze_n));
            chk(hi * 2 == per, "R1 cpu duty", hi, per / 2);
            chk(lead_ok, "R9 early lead one cycle", lead_ok, 1);
            chk(cp_ok, "R12 cpu copies", cp_ok, 1);
            meas_bus(bper, bcp_ok);
            chk(bper == exp_bus_per(fsel, doze_n, bus_full), "R2/R3 bus period", bper,
                exp_bus_per(fsel, doze_n, bus_full));
            chk(bcp_ok, "R12 bus copies", bcp_ok, 1);
            chk(fixed_en == 1 && out_en == 1, "R8 run enables", {fixed_en, out_en}, 3);
        end

        // Directed: doze with half-rate bus gives F/4 on the bus (R3)
        fsel = 2'd0; doze_n = 1'b0; bus_full = 1'b0; mode_req = 3'b111;
        idle(400);
        meas_bus(bper, bcp_ok);
        chk(bper == 72, "R3 doze bus F/4", bper, 72);

        // Stop parks processor and early clocks, bus keeps running (R4)
        doze_n = 1'b1;
        stop_n = 1'b0;
        idle(400);
        ehigh = 0; bcnt = 0;
        repeat (300) begin
            @(negedge clk);
            if (ecpu_clk || cpu_clk != '0) ehigh++;
            if (bus_clk[0]) bcnt++;
        end
        chk(ehigh == 0, "R4 stop holds cpu low", ehigh, 0);
        chk(bcnt > 0, "R4 bus runs in stop", bcnt, 1);
        stop_n = 1'b1;
        meas_cpu(per, hi, lead_ok, cp_ok);
        chk(per == 18 && hi == 9, "R4 release full pulse", hi, 9);

        // Park (R7)
        mode_req = 3'b001;
        idle(400);
        check_quiet(300, "R7 park clocks low");
        chk(fixed_en == 0 && pll_active == 1, "R7 park enables", {fixed_en, pll_active}, 1);

        // High impedance (R8)
        mode_req = 3'b010;
        idle(400);
        chk(out_en == 0, "R8 hiz out_en", out_en, 0);
        meas_cpu(per, hi, lead_ok, cp_ok);
        chk(per == 18, "R8 clocks run in hiz", per, 18);

        // Power-down straight from high impedance (R5 R6)
        enter_down("from hiz");
        check_quiet(200, "R5 down clocks low");
        chk(fixed_en == 0 && pll_active == 0, "R5 down enables", {fixed_en, pll_active}, 0);

        // Leave power-down straight to run (R6)
        begin
            int gap = 0;
            mode_req = 3'b111;
            @(negedge clk);
            while (!fixed_en) begin
                if (pll_active) gap++;
                @(negedge clk);
            end
            chk(gap >= 1 && pll_active, "R6 exit via park", gap, 1);
        end
        meas_cpu(per, hi, lead_ok, cp_ok);
        chk(per == 18, "R5 clocks resume after down", per, 18);

        // Power-down straight from a running mode with slow clocks (R6)
        fsel = 2'd3; doze_n = 1'b0;
        idle(400);
        enter_down("from run");
        check_quiet(100, "R5 down clocks low 2");
        mode_req = 3'b101;
        idle(400);

        // Pulse-width legality across all the above (R10)
        chk(runt_cnt == 0, "R10 pulse widths legal", runt_cnt, 0);
        summary();
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog all requirements actual=%0d expected=0", WATCHDOG);
        summary();
        $finish;
    end
endmodule